// File: doc/BRIEF.md
# Paired-Line Interleaved Write Sequencer

This block sits between a raster pixel source and a display panel that charges two neighbouring rows in the same write slot. Pixels arrive two per clock: one odd dot and one even dot of the current row. A start-of-row marker flags the first pair of every row, and a start-of-frame marker flags the first row of a frame. The block stores the rows and, once a row is complete, plays that row and the row before it out together. The earlier row is the upper group and the newest row is the lower group.

Each output slot carries six lanes per group. The upper group takes even-numbered dots of the older row, and the lower group takes odd-numbered dots of the newer row, from the same twelve-dot window. The two groups in a slot always carry opposite drive polarity, and the polarity flips from one row to the next. The final window of a row is only partly filled, so a lane mask marks which lanes hold real dots. A scan-direction input reverses the window order and the lane order without changing which physical dots are paired. The first row of a frame has no predecessor, so its upper group is flagged invalid and driven to zero.

Top module: `dli_write_seq`

## Requirements
- R1: A row holds LINE_DOTS dots (default 1366), numbered from 1. The input pair accepted at position p of a row (p counted from 0, `pix_sol` high at p=0) carries dot 2p+1 on `pix_odd` and dot 2p+2 on `pix_even`.
- R2: In forward scan, slot s (from 0) places on lane k (bits `[k*DOT_W +: DOT_W]`) the even dot 12s+2k+2 of the previous row on `up_dots`, and the odd dot 12s+2k+1 of the just-completed row on `lo_dots`.
- R3: Each completed row causes one burst of ceil(LINE_DOTS/12) slots (114 by default), with `slot_vld` high on consecutive cycles. The first slot appears two clock edges after the edge that accepts the row's final pair.
- R4: Whenever `slot_vld` is high, `up_pol` and `lo_pol` differ.
- R5: `lo_pol` is 0 for the first burst after reset and inverts on every later burst.
- R6: A lane whose upper dot would lie past dot LINE_DOTS has its `lane_mask` bit at 0, and that lane is zero in both groups. All other lanes have the bit at 1. While `slot_vld` is low, the mask and both dot buses are zero.
- R7: `scan_rev` is sampled on the cycle after a row completes and holds for that burst. When it is 1, slots run from the last one down to slot 0, and lane k carries the pair of window position 5-k. Upper lanes still hold even dots and lower lanes odd dots.
- R8: For a row that began with `pix_sof` high, `up_vld` is 0 and `up_dots` is zero for the whole burst. Otherwise `up_vld` is 1.
- R9: Cycles with `pix_vld` low change no state, so the input stream may pause anywhere within a row.
- R10: During and right after reset, `slot_vld`, `lane_mask`, `up_dots` and `lo_dots` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Input pair present this cycle |
| pix_sol | input | 1 | Pair is the first of a row |
| pix_sof | input | 1 | Row is the first of a frame (with `pix_sol`) |
| pix_odd | input | DOT_W | Odd-numbered dot of the pair |
| pix_even | input | DOT_W | Even-numbered dot of the pair |
| scan_rev | input | 1 | Reverse scan order when high |
| slot_vld | output | 1 | A write slot is presented |
| up_dots | output | 6*DOT_W | Upper group lanes (previous row, even dots) |
| lo_dots | output | 6*DOT_W | Lower group lanes (current row, odd dots) |
| up_pol | output | 1 | Drive polarity of the upper group |
| lo_pol | output | 1 | Drive polarity of the lower group |
| up_vld | output | 1 | Upper group has a real predecessor row |
| lane_mask | output | 6 | Per-lane dot-present flags |

## Verification
The bench targets the short final window, where only five of six lanes are real. A design that miscounts that window would either spill a stale dot into lane 5 or drop dot 1366. Reversed scan is checked with lane values that differ at every dot, so a mapping that flips the odd/even pairing, or reverses the slots without reversing the lanes, shows up as wrong data. A frame restart in the middle of the run tests that the upper group is suppressed even though an older row still sits in storage. Polarity is followed across frame boundaries, and idle cycles inside rows expose any counter that advances on a non-valid cycle.

// File: rtl/dli_pkg.sv
package dli_pkg;

    // Dots of one parity written per group in one slot
    localparam int GRP   = 6;
    // Row stores rotated: one being written, two being played out
    localparam int BANKS = 3;

    typedef logic [1:0] bank_t;

    typedef struct packed {
        bank_t up_bank;
        bank_t lo_bank;
        logic  rev;
        logic  first;
        logic  pol;
    } burst_ctx_t;

    function automatic bank_t bank_prev(bank_t b);
        return (b == 2'd0) ? bank_t'(BANKS - 1) : b - 2'd1;
    endfunction

    function automatic bank_t bank_next(bank_t b);
        return (b == bank_t'(BANKS - 1)) ? 2'd0 : b + 2'd1;
    endfunction

    // Window position feeding output lane k
    function automatic int lane_src(int k, logic rev);
        return rev ? (GRP - 1 - k) : k;
    endfunction

    // Lanes whose pair index falls inside the row
    function automatic logic [GRP-1:0] lane_mask_f(int slot, int pairs, logic rev);
        logic [GRP-1:0] m;
        for (int k = 0; k < GRP; k++) begin
            m[k] = ((slot * GRP + lane_src(k, rev)) < pairs);
        end
        return m;
    endfunction

endpackage

// File: rtl/dli_line_store.sv
module dli_line_store
    import dli_pkg::*;
#(
    parameter  int DOT_W     = 8,
    parameter  int LINE_DOTS = 1366,
    localparam int PAIRS     = LINE_DOTS / 2,
    localparam int SLOTS     = (PAIRS + GRP - 1) / GRP,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_vld,
    input  logic                          in_sol,
    input  logic                          in_sof,
    input  logic [DOT_W-1:0]              in_odd,
    input  logic [DOT_W-1:0]              in_even,
    input  bank_t                         up_bank,
    input  bank_t                         lo_bank,
    input  logic [SLOT_W-1:0]             rd_slot,
    output logic [GRP-1:0][DOT_W-1:0]     up_even,
    output logic [GRP-1:0][DOT_W-1:0]     lo_odd,
    output logic                          done,
    output bank_t                         done_bank,
    output logic                          done_first
);

    localparam int LANE_W     = $clog2(GRP);
    localparam int LAST_LANES = PAIRS - (SLOTS - 1) * GRP;

    // One storage word holds a full slot window: GRP pairs of {even, odd}
    typedef logic [GRP-1:0][2*DOT_W-1:0] word_t;

    word_t               mem_q [BANKS][SLOTS];
    word_t               acc_q, acc_w;
    logic [LANE_W-1:0]   lane_q, cur_lane;
    logic [SLOT_W-1:0]   slot_q, cur_slot;
    logic                first_q, cur_first;
    bank_t               wr_bank_q;
    logic                last_pair, wr_en;

    always_comb begin
        cur_lane  = in_sol ? '0 : lane_q;
        cur_slot  = in_sol ? '0 : slot_q;
        cur_first = in_sol ? in_sof : first_q;
        last_pair = (cur_slot == SLOT_W'(SLOTS - 1)) &&
                    (cur_lane == LANE_W'(LAST_LANES - 1));
        acc_w           = (cur_lane == '0) ? '0 : acc_q;
        acc_w[cur_lane] = {in_even, in_odd};
        wr_en     = in_vld && ((cur_lane == LANE_W'(GRP - 1)) || last_pair);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q     <= '0;
            slot_q     <= '0;
            first_q    <= 1'b0;
            wr_bank_q  <= '0;
            acc_q      <= '0;
            done       <= 1'b0;
            done_bank  <= '0;
            done_first <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_vld) begin
                acc_q   <= acc_w;
                first_q <= cur_first;
                if (last_pair) begin
                    lane_q     <= '0;
                    slot_q     <= '0;
                    wr_bank_q  <= bank_next(wr_bank_q);
                    done       <= 1'b1;
                    done_bank  <= wr_bank_q;
                    done_first <= cur_first;
                end else if (cur_lane == LANE_W'(GRP - 1)) begin
                    lane_q <= '0;
                    slot_q <= cur_slot + SLOT_W'(1);
                end else begin
                    lane_q <= cur_lane + LANE_W'(1);
                    slot_q <= cur_slot;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_bank_q][cur_slot] <= acc_w;
        end
    end

    always_comb begin
        for (int k = 0; k < GRP; k++) begin
            up_even[k] = mem_q[up_bank][rd_slot][k][2*DOT_W-1:DOT_W];
            lo_odd[k]  = mem_q[lo_bank][rd_slot][k][DOT_W-1:0];
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_vld));

endmodule

// File: rtl/dli_slot_reader.sv
module dli_slot_reader
    import dli_pkg::*;
#(
    parameter  int DOT_W     = 8,
    parameter  int LINE_DOTS = 1366,
    localparam int PAIRS     = LINE_DOTS / 2,
    localparam int SLOTS     = (PAIRS + GRP - 1) / GRP,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          done,
    input  bank_t                         done_bank,
    input  logic                          done_first,
    input  logic                          scan_rev,
    output bank_t                         up_bank,
    output bank_t                         lo_bank,
    output logic [SLOT_W-1:0]             rd_slot,
    input  logic [GRP-1:0][DOT_W-1:0]     up_even,
    input  logic [GRP-1:0][DOT_W-1:0]     lo_odd,
    output logic                          slot_vld,
    output logic                          up_vld,
    output logic                          up_pol,
    output logic                          lo_pol,
    output logic [GRP-1:0]                lane_mask,
    output logic [GRP-1:0][DOT_W-1:0]     up_dots,
    output logic [GRP-1:0][DOT_W-1:0]     lo_dots
);

    localparam int CNT_W = $clog2(SLOTS + 1);

    burst_ctx_t                  ctx_q;
    logic                        active_q, pol_q;
    logic [SLOT_W-1:0]           slot_q;
    logic [GRP-1:0]              mask_w;
    logic [GRP-1:0][DOT_W-1:0]   up_w, lo_w;
    logic                        at_end;

    assign up_bank = ctx_q.up_bank;
    assign lo_bank = ctx_q.lo_bank;
    assign rd_slot = slot_q;

    always_comb begin
        mask_w = lane_mask_f(int'(slot_q), PAIRS, ctx_q.rev);
        for (int k = 0; k < GRP; k++) begin
            up_w[k] = (mask_w[k] && !ctx_q.first) ? up_even[lane_src(k, ctx_q.rev)] : '0;
            lo_w[k] = mask_w[k] ? lo_odd[lane_src(k, ctx_q.rev)] : '0;
        end
        at_end = ctx_q.rev ? (slot_q == '0) : (slot_q == SLOT_W'(SLOTS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q     <= '0;
            active_q  <= 1'b0;
            pol_q     <= 1'b0;
            slot_q    <= '0;
            slot_vld  <= 1'b0;
            up_vld    <= 1'b0;
            up_pol    <= 1'b0;
            lo_pol    <= 1'b0;
            lane_mask <= '0;
            up_dots   <= '0;
            lo_dots   <= '0;
        end else begin
            slot_vld <= active_q;
            if (active_q) begin
                lane_mask <= mask_w;
                up_dots   <= up_w;
                lo_dots   <= lo_w;
                up_vld    <= !ctx_q.first;
                up_pol    <= ~ctx_q.pol;
                lo_pol    <= ctx_q.pol;
            end else begin
                lane_mask <= '0;
                up_dots   <= '0;
                lo_dots   <= '0;
                up_vld    <= 1'b0;
                up_pol    <= 1'b0;
                lo_pol    <= 1'b0;
            end

            if (done) begin
                active_q <= 1'b1;
                ctx_q    <= '{up_bank: bank_prev(done_bank), lo_bank: done_bank,
                              rev: scan_rev, first: done_first, pol: pol_q};
                pol_q    <= ~pol_q;
                slot_q   <= scan_rev ? SLOT_W'(SLOTS - 1) : '0;
            end else if (active_q) begin
                if (at_end) begin
                    active_q <= 1'b0;
                end else begin
                    slot_q <= ctx_q.rev ? slot_q - SLOT_W'(1) : slot_q + SLOT_W'(1);
                end
            end
        end
    end

    // Observation state for the checks below
    logic              sv_d, seen_q, last_pol_q;
    logic [CNT_W-1:0]  burst_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sv_d        <= 1'b0;
            seen_q      <= 1'b0;
            last_pol_q  <= 1'b0;
            burst_cnt_q <= '0;
        end else begin
            sv_d        <= slot_vld;
            burst_cnt_q <= slot_vld ? burst_cnt_q + CNT_W'(1) : '0;
            if (slot_vld) begin
                seen_q     <= 1'b1;
                last_pol_q <= lo_pol;
            end
        end
    end

    // R4
    pol_opposite_chk: assert property (@(posedge clk) disable iff (rst)
        slot_vld |-> (up_pol != lo_pol));

    // R5
    pol_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && !sv_d && seen_q) |-> (lo_pol != last_pol_q));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_vld |-> (lane_mask == '0 && up_dots == '0 && lo_dots == '0));

    // R6
    mask_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        slot_vld |-> (lane_mask != '0));

    // R8
    no_pred_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && !up_vld) |-> (up_dots == '0));

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!slot_vld && sv_d) |-> (burst_cnt_q == CNT_W'(SLOTS)));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !active_q);

endmodule

// File: rtl/dli_write_seq.sv
module dli_write_seq
    import dli_pkg::*;
#(
    parameter int DOT_W     = 8,
    parameter int LINE_DOTS = 1366
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pix_vld,
    input  logic                   pix_sol,
    input  logic                   pix_sof,
    input  logic [DOT_W-1:0]       pix_odd,
    input  logic [DOT_W-1:0]       pix_even,
    input  logic                   scan_rev,
    output logic                   slot_vld,
    output logic [GRP*DOT_W-1:0]   up_dots,
    output logic [GRP*DOT_W-1:0]   lo_dots,
    output logic                   up_pol,
    output logic                   lo_pol,
    output logic                   up_vld,
    output logic [GRP-1:0]         lane_mask
);

    localparam int PAIRS  = LINE_DOTS / 2;
    localparam int SLOTS  = (PAIRS + GRP - 1) / GRP;
    localparam int SLOT_W = $clog2(SLOTS);

    bank_t                       up_bank, lo_bank, done_bank;
    logic [SLOT_W-1:0]           rd_slot;
    logic [GRP-1:0][DOT_W-1:0]   up_even, lo_odd, up_arr, lo_arr;
    logic                        done, done_first;

    dli_line_store #(.DOT_W(DOT_W), .LINE_DOTS(LINE_DOTS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (pix_vld),
        .in_sol     (pix_sol),
        .in_sof     (pix_sof),
        .in_odd     (pix_odd),
        .in_even    (pix_even),
        .up_bank    (up_bank),
        .lo_bank    (lo_bank),
        .rd_slot    (rd_slot),
        .up_even    (up_even),
        .lo_odd     (lo_odd),
        .done       (done),
        .done_bank  (done_bank),
        .done_first (done_first)
    );

    dli_slot_reader #(.DOT_W(DOT_W), .LINE_DOTS(LINE_DOTS)) u_reader (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .done_bank  (done_bank),
        .done_first (done_first),
        .scan_rev   (scan_rev),
        .up_bank    (up_bank),
        .lo_bank    (lo_bank),
        .rd_slot    (rd_slot),
        .up_even    (up_even),
        .lo_odd     (lo_odd),
        .slot_vld   (slot_vld),
        .up_vld     (up_vld),
        .up_pol     (up_pol),
        .lo_pol     (lo_pol),
        .lane_mask  (lane_mask),
        .up_dots    (up_arr),
        .lo_dots    (lo_arr)
    );

    assign up_dots = up_arr;
    assign lo_dots = lo_arr;

endmodule

// File: tb/dli_write_seq_test.sv
`timescale 1ns/1ps
module dli_write_seq_test;

    localparam int DW    = 8;
    localparam int LD    = 1366;
    localparam int G     = 6;
    localparam int PAIRS = LD / 2;
    localparam int SLOTS = (PAIRS + G - 1) / G;

    logic clk = 1'b0, rst = 1'b1;
    logic pix_vld = 1'b0, pix_sol = 1'b0, pix_sof = 1'b0, scan_rev = 1'b0;
    logic [DW-1:0] pix_odd = '0, pix_even = '0;
    logic slot_vld, up_pol, lo_pol, up_vld;
    logic [G*DW-1:0] up_dots, lo_dots;
    logic [G-1:0] lane_mask;

    dli_write_seq #(.DOT_W(DW), .LINE_DOTS(LD)) uut (
        .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_sol(pix_sol), .pix_sof(pix_sof),
        .pix_odd(pix_odd), .pix_even(pix_even), .scan_rev(scan_rev),
        .slot_vld(slot_vld), .up_dots(up_dots), .lo_dots(lo_dots),
        .up_pol(up_pol), .lo_pol(lo_pol), .up_vld(up_vld), .lane_mask(lane_mask)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 1'b0, prev_sv = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [G*DW-1:0] q_up[$], q_lo[$];
    logic [G-1:0]    q_mask[$];
    bit              q_uv[$], q_pol[$];
    int              q_start[$];
    int cur_px[LD];
    int prev_px[LD];
    bit pol_m = 1'b0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic int pv(int f, int l, int d);
        return (d * 5 + l * 17 + f * 41 + 3) % 256;
    endfunction

    // Reference: expected slots for the row just sent (R2, R6, R7, R8, R5)
    task automatic build(bit first_row);
        for (int i = 0; i < SLOTS; i++) begin
            int s;
            logic [G*DW-1:0] u, lo;
            logic [G-1:0] m;
            s = scan_rev ? (SLOTS - 1 - i) : i;
            u = '0; lo = '0; m = '0;
            for (int k = 0; k < G; k++) begin
                int j, pi;
                j  = scan_rev ? (G - 1 - k) : k;
                pi = s * G + j;
                if (pi < PAIRS) begin
                    m[k] = 1'b1;
                    lo[k*DW +: DW] = DW'(cur_px[2*pi]);
                    if (!first_row) u[k*DW +: DW] = DW'(prev_px[2*pi + 1]);
                end
            end
            q_up.push_back(u);
            q_lo.push_back(lo);
            q_mask.push_back(m);
            q_uv.push_back(!first_row);
            q_pol.push_back(pol_m);
        end
        for (int d = 0; d < LD; d++) prev_px[d] = cur_px[d];
        pol_m = ~pol_m;
    endtask

    // R1 pair ordering; R9 idle cycles inserted inside the row
    task automatic send_row(int f, int l, bit first_row);
        for (int p = 0; p < PAIRS; p++) begin
            if (p % 97 == 50) begin
                @(negedge clk);
                pix_vld = 1'b0;
                pix_odd = 8'hEE;
                pix_even = 8'hDD;
            end
            @(negedge clk);
            pix_vld  = 1'b1;
            pix_sol  = (p == 0);
            pix_sof  = first_row && (p == 0);
            pix_odd  = DW'(pv(f, l, 2*p + 1));
            pix_even = DW'(pv(f, l, 2*p + 2));
            cur_px[2*p]     = pv(f, l, 2*p + 1);
            cur_px[2*p + 1] = pv(f, l, 2*p + 2);
        end
        @(negedge clk);
        pix_vld = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
        q_start.push_back(cyc + 2);
        build(first_row);
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (slot_vld) begin
                if (!prev_sv) begin
                    if (q_start.size() == 0) chk(1'b0, "R3", "burst with no row", cyc, 0);
                    else begin
                        int e;
                        e = q_start.pop_front();
                        chk(cyc == e, "R3", "burst start cycle", cyc, e);
                    end
                end
                if (q_up.size() == 0) begin
                    chk(1'b0, "R3", "unexpected slot", 1, 0);
                end else begin
                    logic [G*DW-1:0] eu, el;
                    logic [G-1:0] em;
                    bit ev, ep;
                    eu = q_up.pop_front(); el = q_lo.pop_front(); em = q_mask.pop_front();
                    ev = q_uv.pop_front(); ep = q_pol.pop_front();
                    chk(lo_dots == el, "R1 R2 R7 R9", "lower dots", lo_dots, el);
                    chk(up_dots == eu, "R2 R7 R8", "upper dots", up_dots, eu);
                    chk(lane_mask == em, "R6", "lane mask", lane_mask, em);
                    chk(up_vld == ev, "R8", "upper valid", up_vld, ev);
                    chk(lo_pol == ep, "R5", "lower polarity", lo_pol, ep);
                    chk(up_pol != lo_pol, "R4", "polarity pair", up_pol, !lo_pol);
                end
            end else begin
                chk(lane_mask == '0 && up_dots == '0 && lo_dots == '0, "R6",
                    "idle outputs", {lane_mask, lo_dots[7:0]}, 0);
            end
            prev_sv = slot_vld;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 during reset
        chk(slot_vld == 1'b0 && lane_mask == '0, "R10", "in reset", {slot_vld, lane_mask}, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 right after reset
        chk(slot_vld == 1'b0 && up_dots == '0 && lo_dots == '0, "R10", "after reset",
            {slot_vld, up_dots[7:0]}, 0);

        send_row(0, 0, 1'b1);
        send_row(0, 1, 1'b0);
        send_row(0, 2, 1'b0);
        repeat (150) @(negedge clk);
        scan_rev = 1'b1;
        send_row(1, 0, 1'b1);
        send_row(1, 1, 1'b0);
        send_row(1, 2, 1'b0);
        repeat (150) @(negedge clk);
        scan_rev = 1'b0;
        send_row(2, 0, 1'b1);
        send_row(2, 1, 1'b0);
        repeat (200) @(negedge clk);
        // R3 every expected slot was produced
        chk(q_up.size() == 0 && q_start.size() == 0, "R3", "slots left over", q_up.size(), 0);
        wrap_up();
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            wrap_up();
        end
    end

endmodule